// File: doc/BRIEF.md
# Iterative Multiply, Divide and Root Step Datapath

This block is a 16-bit arithmetic datapath organised around a top register T and a second register N, with two support registers: MD for multiply and divide, and SR for square root. Every clock cycle it can either load one register from a data bus or run one command. A command is a plain add or subtract, a carry-chained add or subtract, a 16-bit or 32-bit arithmetic right shift, or one iteration of a longer operation. The longer operations are unsigned, signed and fractional multiply, nonrestoring divide with its closing correction, and integer square root.

A long operation is built by the controller around the block. It loads the operands and then issues one step command per clock for the required number of cycles. The block does not count steps itself. The command and load pins are plain control inputs with no handshake: the block accepts a command or a load on every cycle and never stalls, so there is no back-pressure to manage. The adder always takes T as one operand, and the other operand is chosen from N, MD, SR or zero. A small shifter sits on the adder output.

Top module: `mdstep_core`

## Requirements
- R1: While rst_n is low, T, N, MD, SR, the carry flag and the internal step bit are all cleared to zero.
- R2: When ld_en is high, ld_data is written on the next edge into the register chosen by ld_sel (0 = T, 1 = N, 2 = MD, 3 = SR). A command presented in the same cycle is ignored. Loading T or N also clears the internal step bit.
- R3: When cmd_en is high and ld_en is low, cmd_op 1 (ADD) writes T + B into T and cmd_op 3 (SUB) writes T + ~B + 1 into T. B is chosen by cmd_src (0 = N, 1 = MD, 2 = SR, 3 = zero). The adder's carry-out goes to the carry flag, so after SUB a 1 means no borrow.
- R4: cmd_op 2 (ADDC) computes T + B + carry and cmd_op 4 (SUBC) computes T + ~B + carry. The carry flag keeps its value across loads, idle cycles and all other commands; only opcodes 1 to 4 change it.
- R5: For opcodes 1 to 4, cmd_shf post-shifts the 16-bit sum before it is written to T: 0 = none, 1 = left by one, 2 = arithmetic right by one, 3 = logical right by one. The carry flag still takes the unshifted adder carry-out.
- R6: cmd_op 5 shifts T right arithmetically by one bit and leaves N unchanged.
- R7: cmd_op 6 shifts the 32-bit pair T:N (T high) right arithmetically by one bit, and bit 0 of T moves into bit 15 of N.
- R8: Start with T = 0, N = multiplier and MD = multiplicand. Sixteen cmd_op 7 steps leave the unsigned 32-bit product in T:N.
- R9: Start with T = 0, N = multiplier, MD = multiplicand, and the step bit cleared by loading T or N. Sixteen cmd_op 8 steps leave the two's-complement 32-bit product in T:N.
- R10: With the same setup as R9, fifteen cmd_op 8 steps followed by one cmd_op 9 step leave the signed product shifted left by one (modulo 2^32) in T:N, which is the Q15-by-Q15 fractional product.
- R11: Start with T:N = 32-bit dividend (T high), MD = a nonzero divisor and T below MD, and the step bit cleared by loading T or N. Sixteen cmd_op 10 steps followed by one cmd_op 11 step leave the remainder in T and the quotient in N.
- R12: Start with T = 0, SR = 0 and N = the radicand. Eight cmd_op 12 steps leave floor(sqrt(N)) in SR and the radicand minus the root squared in T.
- R13: A cycle with both cmd_en and ld_en low leaves T, N and the carry flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_en | input | 1 | Runs the command on cmd_op this cycle |
| cmd_op | input | 4 | Command code (see R3 to R12) |
| cmd_src | input | 2 | Second adder operand select |
| cmd_shf | input | 2 | Shifter control on the adder output |
| ld_en | input | 1 | Register load strobe; has priority over cmd_en |
| ld_sel | input | 2 | Register written by a load |
| ld_data | input | 16 | Load value |
| t_out | output | 16 | Current T |
| n_out | output | 16 | Current N |
| carry_out | output | 1 | Current carry flag |

## Verification
The assertions check the single-cycle behaviours on every cycle. These are: load priority and the load result in T and N, hold on idle cycles, the carry flag staying fixed outside opcodes 1 to 4, both arithmetic shifts, and the plain add with N. Products, quotients, remainders and roots only appear after a sequence of 8 to 17 steps, so the bench's sweeps have to show them. The bench compares each result with arithmetic done in the bench, using corner operands (zero, all ones, most negative, most positive) together with spread random values. The bench also shows that ADDC and SUBC chain correctly into 32-bit results, and that a long multiply leaves the carry flag untouched.

// File: rtl/mdstep_pkg.sv
package mdstep_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBC = 4'd4,
    OP_ASR  = 4'd5,
    OP_DASR = 4'd6,
    OP_MULU = 4'd7,
    OP_MULS = 4'd8,
    OP_MULF = 4'd9,
    OP_DIV  = 4'd10,
    OP_DIVL = 4'd11,
    OP_SQRT = 4'd12
  } step_op_e;

  typedef enum logic [1:0] {
    SRC_N    = 2'd0,
    SRC_MD   = 2'd1,
    SRC_SR   = 2'd2,
    SRC_ZERO = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_LEFT = 2'd1,
    SH_ASR  = 2'd2,
    SH_LSR  = 2'd3
  } shf_e;

  typedef enum logic [1:0] {
    LD_T  = 2'd0,
    LD_N  = 2'd1,
    LD_MD = 2'd2,
    LD_SR = 2'd3
  } ld_e;

endpackage

// File: rtl/mdstep_addsub.sv
module mdstep_addsub import mdstep_pkg::*; #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  input  logic [1:0]   shf_i,
  output logic [W-1:0] y_o,
  output logic         cout_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic [W-1:0] raw;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    raw    = full[W-1:0];
    cout_o = full[W];
    case (shf_e'(shf_i))
      SH_LEFT: y_o = {raw[W-2:0], 1'b0};
      SH_ASR:  y_o = {raw[W-1], raw[W-1:1]};
      SH_LSR:  y_o = {1'b0, raw[W-1:1]};
      default: y_o = raw;
    endcase
  end
endmodule

// File: rtl/mdstep_mul.sv
module mdstep_mul #(
  parameter int W = 16
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] md_i,
  input  logic         aux_i,
  input  logic         signed_i,
  input  logic         frac_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] n_o,
  output logic         aux_o
);
  logic [W:0] t_ext;
  logic [W:0] md_ext;
  logic [W:0] sum;

  always_comb begin
    t_ext  = signed_i ? {t_i[W-1], t_i}   : {1'b0, t_i};
    md_ext = signed_i ? {md_i[W-1], md_i} : {1'b0, md_i};
    sum    = t_ext;
    if (signed_i) begin
      // radix-2 recoding of multiplier bit pair {current, previous}
      if (n_i[0] && !aux_i)      sum = t_ext - md_ext;
      else if (!n_i[0] && aux_i) sum = t_ext + md_ext;
    end else if (n_i[0]) begin
      sum = t_ext + md_ext;
    end
    if (frac_i) begin
      // closing step of a fractional product: keep the sum in place
      t_o = sum[W-1:0];
      n_o = {n_i[W-1:1], 1'b0};
    end else begin
      t_o = sum[W:1];
      n_o = {sum[0], n_i[W-1:1]};
    end
    aux_o = signed_i ? n_i[0] : aux_i;
  end
endmodule

// File: rtl/mdstep_div.sv
module mdstep_div #(
  parameter int W = 16
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] md_i,
  input  logic         aux_i,
  input  logic         last_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] n_o,
  output logic         aux_o
);
  // Partial remainder is the signed value {aux, T}; it always fits W+1 bits.
  logic [W:0] rsh;
  logic [W:0] rnew;

  always_comb begin
    rsh  = {t_i, n_i[W-1]};
    rnew = aux_i ? (rsh + {1'b0, md_i}) : (rsh - {1'b0, md_i});
    if (last_i) begin
      t_o   = aux_i ? (t_i + md_i) : t_i;
      n_o   = n_i;
      aux_o = 1'b0;
    end else begin
      t_o   = rnew[W-1:0];
      n_o   = {n_i[W-2:0], ~rnew[W]};
      aux_o = rnew[W];
    end
  end
endmodule

// File: rtl/mdstep_sqrt.sv
module mdstep_sqrt #(
  parameter int W = 16
) (
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] n_o,
  output logic [W-1:0] sr_o
);
  localparam int RW = W + 2;

  logic [RW-1:0] rsh;
  logic [RW-1:0] trial;
  logic [W-1:0]  diff;
  logic          fits;

  always_comb begin
    rsh   = {t_i, n_i[W-1:W-2]};
    trial = {sr_i, 2'b01};
    fits  = (rsh >= trial);
    diff  = rsh[W-1:0] - trial[W-1:0];
    t_o   = fits ? diff : rsh[W-1:0];
    sr_o  = {sr_i[W-2:0], fits};
    n_o   = {n_i[W-3:0], 2'b00};
  end
endmodule

// File: rtl/mdstep_core.sv
module mdstep_core import mdstep_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_en,
  input  logic [3:0]   cmd_op,
  input  logic [1:0]   cmd_src,
  input  logic [1:0]   cmd_shf,
  input  logic         ld_en,
  input  logic [1:0]   ld_sel,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] t_out,
  output logic [W-1:0] n_out,
  output logic         carry_out
);
  localparam logic [W-1:0] ZERO_W = '0;

  logic [W-1:0] t_q, n_q, md_q, sr_q;
  logic         c_q, aux_q;
  logic [W-1:0] t_d, n_d, md_d, sr_d;
  logic         c_d, aux_d;

  step_op_e op;
  src_e     src;
  assign op  = step_op_e'(cmd_op);
  assign src = src_e'(cmd_src);

  // adder with operand select and output shifter
  logic [W-1:0] alu_b, alu_y;
  logic         alu_cin, alu_sub, alu_co;

  always_comb begin
    case (src)
      SRC_N:   alu_b = n_q;
      SRC_MD:  alu_b = md_q;
      SRC_SR:  alu_b = sr_q;
      default: alu_b = ZERO_W;
    endcase
    alu_sub = (op == OP_SUB) || (op == OP_SUBC);
    case (op)
      OP_ADDC, OP_SUBC: alu_cin = c_q;
      OP_SUB:           alu_cin = 1'b1;
      default:          alu_cin = 1'b0;
    endcase
  end

  mdstep_addsub #(.W(W)) addsub_i (
    .a_i(t_q), .b_i(alu_b), .cin_i(alu_cin), .sub_i(alu_sub),
    .shf_i(cmd_shf), .y_o(alu_y), .cout_o(alu_co)
  );

  // multiply step
  logic [W-1:0] mul_t, mul_n;
  logic         mul_aux;
  mdstep_mul #(.W(W)) mul_i (
    .t_i(t_q), .n_i(n_q), .md_i(md_q), .aux_i(aux_q),
    .signed_i((op == OP_MULS) || (op == OP_MULF)),
    .frac_i(op == OP_MULF),
    .t_o(mul_t), .n_o(mul_n), .aux_o(mul_aux)
  );

  // divide step and fixup
  logic [W-1:0] div_t, div_n;
  logic         div_aux;
  mdstep_div #(.W(W)) div_i (
    .t_i(t_q), .n_i(n_q), .md_i(md_q), .aux_i(aux_q),
    .last_i(op == OP_DIVL),
    .t_o(div_t), .n_o(div_n), .aux_o(div_aux)
  );

  // square-root step
  logic [W-1:0] sq_t, sq_n, sq_sr;
  mdstep_sqrt #(.W(W)) sqrt_i (
    .t_i(t_q), .n_i(n_q), .sr_i(sr_q),
    .t_o(sq_t), .n_o(sq_n), .sr_o(sq_sr)
  );

  always_comb begin
    t_d   = t_q;
    n_d   = n_q;
    md_d  = md_q;
    sr_d  = sr_q;
    c_d   = c_q;
    aux_d = aux_q;
    if (ld_en) begin
      case (ld_e'(ld_sel))
        LD_T:    begin t_d = ld_data; aux_d = 1'b0; end
        LD_N:    begin n_d = ld_data; aux_d = 1'b0; end
        LD_MD:   md_d = ld_data;
        default: sr_d = ld_data;
      endcase
    end else if (cmd_en) begin
      case (op)
        OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
          t_d = alu_y;
          c_d = alu_co;
        end
        OP_ASR:  t_d = {t_q[W-1], t_q[W-1:1]};
        OP_DASR: {t_d, n_d} = {t_q[W-1], t_q, n_q[W-1:1]};
        OP_MULU, OP_MULS, OP_MULF: begin
          t_d   = mul_t;
          n_d   = mul_n;
          aux_d = mul_aux;
        end
        OP_DIV, OP_DIVL: begin
          t_d   = div_t;
          n_d   = div_n;
          aux_d = div_aux;
        end
        OP_SQRT: begin
          t_d  = sq_t;
          n_d  = sq_n;
          sr_d = sq_sr;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q   <= '0;
      n_q   <= '0;
      md_q  <= '0;
      sr_q  <= '0;
      c_q   <= 1'b0;
      aux_q <= 1'b0;
    end else begin
      t_q   <= t_d;
      n_q   <= n_d;
      md_q  <= md_d;
      sr_q  <= sr_d;
      c_q   <= c_d;
      aux_q <= aux_d;
    end
  end

  assign t_out     = t_q;
  assign n_out     = n_q;
  assign carry_out = c_q;
endmodule

// File: rtl/mdstep_core_chk.sv
module mdstep_core_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_en,
  input logic [3:0]   cmd_op,
  input logic [1:0]   cmd_src,
  input logic [1:0]   cmd_shf,
  input logic         ld_en,
  input logic [1:0]   ld_sel,
  input logic [W-1:0] ld_data,
  input logic [W-1:0] t_out,
  input logic [W-1:0] n_out,
  input logic         carry_out
);
  logic run, arith;
  assign run   = cmd_en && !ld_en;
  assign arith = (cmd_op >= 4'd1) && (cmd_op <= 4'd4);

  a_r2_load_t: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 2'd0) |=> (t_out == $past(ld_data)));

  a_r2_load_n: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 2'd1) |=> (n_out == $past(ld_data)));

  a_r3_add_n: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd_op == 4'd1 && cmd_src == 2'd0 && cmd_shf == 2'd0)
    |=> ({carry_out, t_out} == ({1'b0, $past(t_out)} + {1'b0, $past(n_out)})));

  a_r4_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !arith) |=> $stable(carry_out));

  a_r6_asr_t: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd_op == 4'd5)
    |=> (t_out == {$past(t_out[W-1]), $past(t_out[W-1:1])}) && (n_out == $past(n_out)));

  a_r7_asr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cmd_op == 4'd6)
    |=> ({t_out, n_out} == {$past(t_out[W-1]), $past(t_out), $past(n_out[W-1:1])}));

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_en && !ld_en) |=> ($stable(t_out) && $stable(n_out) && $stable(carry_out)));
endmodule

bind mdstep_core mdstep_core_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
  .cmd_src(cmd_src), .cmd_shf(cmd_shf), .ld_en(ld_en), .ld_sel(ld_sel),
  .ld_data(ld_data), .t_out(t_out), .n_out(n_out), .carry_out(carry_out)
);

// File: tb/mdstep_core_tb_top.sv
module mdstep_core_tb_top;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_en = 1'b0;
  logic [3:0]   cmd_op = '0;
  logic [1:0]   cmd_src = '0;
  logic [1:0]   cmd_shf = '0;
  logic         ld_en = 1'b0;
  logic [1:0]   ld_sel = '0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] t_out, n_out;
  logic         carry_out;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdstep_core #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_shf(cmd_shf), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .t_out(t_out), .n_out(n_out), .carry_out(carry_out)
  );

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ld(input logic [1:0] sel, input logic [W-1:0] d);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] src, input logic [1:0] shf);
    cmd_en = 1'b1; cmd_op = op; cmd_src = src; cmd_shf = shf;
    @(negedge clk);
    cmd_en = 1'b0;
  endtask

  function automatic logic [15:0] corner(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  // kind 0: unsigned (R8), 1: signed (R9), 2: fractional (R10)
  task automatic run_mul(input int kind, input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] sa, sb;
    logic [31:0] e;
    ld(2'd0, 16'h0000); ld(2'd1, b); ld(2'd2, a);
    for (int s = 0; s < 16; s++) begin
      if (kind == 0) cmd(4'd7, 2'd0, 2'd0);
      else if (kind == 2 && s == 15) cmd(4'd9, 2'd0, 2'd0);
      else cmd(4'd8, 2'd0, 2'd0);
    end
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    if (kind == 0) e = {16'h0, a} * {16'h0, b};
    else if (kind == 1) e = sa * sb;
    else e = (sa * sb) << 1;
    if (kind == 0) chk("R8 unsigned product", {1'b0, t_out, n_out}, {1'b0, e});
    else if (kind == 1) chk("R9 signed product", {1'b0, t_out, n_out}, {1'b0, e});
    else chk("R10 fractional product", {1'b0, t_out, n_out}, {1'b0, e});
  endtask

  task automatic run_div(input logic [15:0] hi, input logic [15:0] lo, input logic [15:0] d);
    logic [31:0] dv, q, r;
    ld(2'd0, hi); ld(2'd1, lo); ld(2'd2, d);
    for (int s = 0; s < 16; s++) cmd(4'd10, 2'd0, 2'd0);
    cmd(4'd11, 2'd0, 2'd0);
    dv = {hi, lo};
    q = dv / {16'h0, d};
    r = dv % {16'h0, d};
    chk("R11 quotient", {17'h0, n_out}, {1'b0, q});
    chk("R11 remainder", {17'h0, t_out}, {1'b0, r});
  endtask

  task automatic run_sqrt(input int x);
    int r;
    r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    ld(2'd0, 16'h0); ld(2'd3, 16'h0); ld(2'd1, 16'(x));
    for (int s = 0; s < 8; s++) cmd(4'd12, 2'd0, 2'd0);
    chk("R12 remainder", {17'h0, t_out}, 33'(x - r * r));
    ld(2'd0, 16'h0);
    cmd(4'd1, 2'd2, 2'd0);
    chk("R12 root", {17'h0, t_out}, 33'(r));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] a, b, m, s;
    logic [31:0] x32, y32, z32;
    logic [16:0] e17;
    logic        cbefore;

    repeat (3) @(negedge clk);
    chk("R1 reset T N carry", {t_out, n_out, carry_out}, 33'h0);
    rst_n = 1'b1;
    @(negedge clk);
    cmd(4'd1, 2'd1, 2'd0);
    chk("R1 MD cleared", {16'h0, carry_out, t_out}, 33'h0);
    cmd(4'd1, 2'd2, 2'd0);
    chk("R1 SR cleared", {16'h0, carry_out, t_out}, 33'h0);

    // R3 / R2: each operand source, add and subtract
    for (int i = 0; i < 40; i++) begin
      a = corner(i % 6); b = corner((i + 2) % 7);
      m = b ^ 16'h5A5A; s = ~b + 16'h0033;
      ld(2'd0, a); ld(2'd1, b); ld(2'd2, m); ld(2'd3, s);
      cmd(4'd1, 2'd0, 2'd0);
      chk("R3 add N", {16'h0, carry_out, t_out}, {16'h0, {1'b0, a} + {1'b0, b}});
      ld(2'd0, a);
      cmd(4'd3, 2'd1, 2'd0);
      chk("R3 sub MD", {16'h0, carry_out, t_out}, {16'h0, {1'b0, a} + {1'b0, ~m} + 17'd1});
      ld(2'd0, a);
      cmd(4'd1, 2'd2, 2'd0);
      chk("R3 add SR", {16'h0, carry_out, t_out}, {16'h0, {1'b0, a} + {1'b0, s}});
      ld(2'd0, a);
      cmd(4'd1, 2'd3, 2'd0);
      chk("R3 add zero", {16'h0, carry_out, t_out}, {17'h0, a});
    end

    // R4: 32-bit add and subtract chained through the carry flag
    for (int i = 0; i < 40; i++) begin
      x32 = (i == 0) ? 32'h0000_FFFF : $urandom;
      y32 = (i == 0) ? 32'h0000_0001 : $urandom;
      ld(2'd0, x32[15:0]); ld(2'd1, y32[15:0]);
      cmd(4'd1, 2'd0, 2'd0);
      ld(2'd0, x32[31:16]); ld(2'd1, y32[31:16]);
      cmd(4'd2, 2'd0, 2'd0);
      z32 = x32 + y32;
      chk("R4 addc high half", {17'h0, t_out}, {17'h0, z32[31:16]});
      ld(2'd0, x32[15:0]); ld(2'd1, y32[15:0]);
      cmd(4'd3, 2'd0, 2'd0);
      ld(2'd0, x32[31:16]); ld(2'd1, y32[31:16]);
      cmd(4'd4, 2'd0, 2'd0);
      z32 = x32 - y32;
      chk("R4 subc high half", {17'h0, t_out}, {17'h0, z32[31:16]});
    end

    // R5: output shifter, carry from the unshifted sum
    for (int i = 0; i < 32; i++) begin
      a = corner(i % 5); b = 16'($urandom);
      e17 = {1'b0, a} + {1'b0, b};
      ld(2'd0, a); ld(2'd1, b);
      cmd(4'd1, 2'd0, 2'(i % 4));
      case (i % 4)
        0: chk("R5 shift none", {16'h0, carry_out, t_out}, {16'h0, e17});
        1: chk("R5 shift left", {16'h0, carry_out, t_out}, {16'h0, e17[16], e17[14:0], 1'b0});
        2: chk("R5 shift arith right", {16'h0, carry_out, t_out}, {16'h0, e17[16], e17[15], e17[15:1]});
        default: chk("R5 shift logic right", {16'h0, carry_out, t_out}, {16'h0, e17[16], 1'b0, e17[15:1]});
      endcase
    end

    // R6 / R7: arithmetic shifts
    for (int i = 0; i < 16; i++) begin
      a = corner(i % 6); b = 16'($urandom);
      ld(2'd0, a); ld(2'd1, b);
      cmd(4'd5, 2'd0, 2'd0);
      chk("R6 asr T, N kept", {1'b0, t_out, n_out}, {1'b0, a[15], a[15:1], b});
      ld(2'd0, a);
      cmd(4'd6, 2'd0, 2'd0);
      chk("R7 asr T:N", {1'b0, t_out, n_out}, {1'b0, a[15], a, b[15:1]});
    end

    // R2: load wins over a command in the same cycle; R13: idle holds
    ld(2'd0, 16'hFFFF); ld(2'd1, 16'h0001);
    cmd(4'd1, 2'd0, 2'd0);
    chk("R4 carry set", {32'h0, carry_out}, 33'h1);
    ld_en = 1'b1; ld_sel = 2'd0; ld_data = 16'h1234;
    cmd_en = 1'b1; cmd_op = 4'd3; cmd_src = 2'd0; cmd_shf = 2'd0;
    @(negedge clk);
    ld_en = 1'b0; cmd_en = 1'b0;
    chk("R2 load overrides command", {carry_out, t_out, n_out}, {1'b1, 16'h1234, 16'h0001});
    repeat (3) @(negedge clk);
    chk("R13 idle hold", {carry_out, t_out, n_out}, {1'b1, 16'h1234, 16'h0001});

    // R8..R10 multiply sweeps; R4 carry kept across a long operation
    cbefore = carry_out;
    run_mul(0, 16'hFFFF, 16'hFFFF);
    chk("R4 carry kept across multiply", {32'h0, carry_out}, {32'h0, cbefore});
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 500; i++) begin
        a = (i < 20) ? corner(i % 4) : 16'($urandom);
        b = (i < 20) ? corner(i / 4 % 4 + (i >= 16 ? 4 : 0)) : 16'($urandom);
        run_mul(k, a, b);
      end
    end

    // R11 divide sweep
    for (int i = 0; i < 600; i++) begin
      case (i)
        0: m = 16'h0001;
        1: m = 16'hFFFF;
        2: m = 16'h8000;
        default: m = 16'($urandom) | 16'h0001;
      endcase
      a = (i == 1) ? 16'hFFFE : 16'(32'($urandom) % {16'h0, m});
      b = (i == 1) ? 16'hFFFF : 16'($urandom);
      run_div(a, b, m);
    end

    // R12 square-root sweep
    for (int x = 0; x < 65536; x += 23) run_sqrt(x);
    run_sqrt(65535);
    run_sqrt(65025);
    run_sqrt(65024);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule